// File: doc/BRIEF.md
# Serial EEPROM Read Engine

This block is the target side of a two-wire serial EEPROM that holds 512 bytes and supports reads only. It watches a synchronised copy of the clock and data lines, detects START and STOP conditions, and decodes the device address byte. It serves three kinds of read. A current-address read starts at the retained internal counter. A random read first takes a word address through a dummy write. A sequential read streams one byte after another for as long as the controller acknowledges each byte.

The data line is modelled as three separate signals: the sampled bus level, the sampled clock level, and an output enable that pulls the line low. The array behind the engine has computed contents and a registered read port. The top address bit travels in the device address byte. The low eight address bits come either from a word address byte or from the counter, which steps through the full 9-bit space.

Top module: `eeprom_rd_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `sda_oe` is 0 (the line is released) until a valid device address has been received.
- R2: After a START, a device address byte whose bits 7:4 equal 4'b1010 is acknowledged by driving `sda_oe` high during the ninth clock. Bit 0 selects the direction (1 = read, 0 = write) and bit 1 carries address bit 8. Bits 3:2 are not checked.
- R3: A device address byte whose bits 7:4 differ from 4'b1010 is not acknowledged. The line stays released until the next START.
- R4: A random read works as follows. A write-direction device byte and a word address byte are each acknowledged. A repeated START and a read-direction device byte then follow. The first byte returned comes from address {device bit 1, word address}.
- R5: Data bytes are sent MSB first. The byte at address a is a[7:0] XOR 8'hAB when a[8] is 1, and a[7:0] XOR 8'h2B otherwise. The line changes only while the clock is low.
- R6: Each time the controller acknowledges byte n, the next byte sent comes from address n+1.
- R7: In a sequential read, the byte after address 511 comes from address 0.
- R8: After a byte that the controller does not acknowledge, the line stays released through later clock pulses until a START. The counter then holds one past the last address read.
- R9: A current-address read with no word address setup reads from {device bit 1, counter bits 7:0}.
- R10: A STOP returns the engine to idle. A byte clocked in after a STOP with no START in between is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Every response follows an SCL edge after a fixed delay. Two synchroniser flops, one edge-detect flop and the state register put a new `sda_oe` value about four system cycles after the SCL fall that caused it. The bench holds each SCL phase for ten system cycles, so the engine's output has settled well before the next rising edge. The bench reads acknowledge and data bits five cycles into each high phase, while both the controller and the engine hold the line steady. Expected bytes come from the content formula in R5, worked out by hand for each address.

// File: rtl/eer_pkg.sv
package eer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_WADDR,
    ST_WACK,
    ST_TX,
    ST_TXACK
  } eer_state_t;

endpackage

// File: rtl/eer_bus_sync.sv
module eer_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eer_array.sv
module eer_array #(
  parameter int               ADDR_W = 9,
  parameter int               DATA_W = 8,
  parameter logic [DATA_W-1:0] SEED  = 8'h2B,
  parameter logic [DATA_W-1:0] UPPER = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DATA_W-1:0] HI_KEY = SEED | UPPER;

  logic [DATA_W-1:0] cell_d;

  always_comb begin
    cell_d = rd_addr[DATA_W-1:0] ^ (rd_addr[ADDR_W-1] ? HI_KEY : SEED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= cell_d;
    end
  end

endmodule

// File: rtl/eeprom_rd_engine.sv
module eeprom_rd_engine
  import eer_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;
  localparam int BIT_W  = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] RX_DONE = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] TX_LAST = BIT_W'(BYTE_W - 1);

  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eer_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eer_state_t        state_q, state_d;
  logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              rw_q, rw_d;
  logic              ack_q, ack_d;
  logic [BYTE_W-1:0] mem_q;

  eer_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .rd_addr (cnt_q),
    .rd_data (mem_q)
  );

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    rw_d     = rw_q;
    ack_d    = ack_q;
    if (start_det) begin
      state_d  = ST_DEV;
      bitcnt_d = '0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR: begin
          if (scl_rise) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == RX_DONE) begin
            bitcnt_d = '0;
            if (state_q == ST_DEV) begin
              if (shreg_q[BYTE_W-1 -: 4] == DEV_TYPE) begin
                state_d           = ST_DEVACK;
                rw_d              = shreg_q[0];
                cnt_d[ADDR_W-1]   = shreg_q[1];
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              state_d             = ST_WACK;
              cnt_d[BYTE_W-1:0]   = shreg_q;
            end
          end
        end
        ST_DEVACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (rw_q) begin
              state_d = ST_TX;
              shreg_d = mem_q;
              cnt_d   = cnt_q + 1'b1;
            end else begin
              state_d = ST_WADDR;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            state_d = ST_IDLE;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == TX_LAST) begin
              state_d = ST_TXACK;
            end else begin
              shreg_d  = {shreg_q[BYTE_W-2:0], 1'b0};
              bitcnt_d = bitcnt_q + 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            bitcnt_d = '0;
            if (ack_q) begin
              state_d = ST_TX;
              shreg_d = mem_q;
              cnt_d   = cnt_q + 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      cnt_q    <= '0;
      rw_q     <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      cnt_q    <= cnt_d;
      rw_q     <= rw_d;
      ack_q    <= ack_d;
    end
  end

  assign sda_oe = (state_q == ST_DEVACK) || (state_q == ST_WACK) ||
                  ((state_q == ST_TX) && !shreg_q[BYTE_W-1]);

endmodule

// File: rtl/eer_checker.sv
module eer_checker
  import eer_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter int         ADDR_W   = 9,
  parameter int         BYTE_W   = 8,
  parameter int         BIT_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input eer_state_t        state_q,
  input logic [ADDR_W-1:0] cnt_q,
  input logic              ack_q,
  input logic [BIT_W-1:0]  bitcnt_q,
  input logic [BYTE_W-1:0] shreg_q
);

  // R2: a START always restarts address reception
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_DEV && bitcnt_q == '0));

  // R3: a foreign device type drops to idle with the line released
  a_r3_foreign_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEV && scl_fall && bitcnt_q == BIT_W'(BYTE_W) &&
     shreg_q[BYTE_W-1 -: 4] != DEV_TYPE && !start_det && !stop_det)
    |=> (state_q == ST_IDLE && !sda_oe));

  // R5: the line is only changed while the clock is low
  a_r5_sda_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R6 and R7: each streamed byte advances the counter by one, modulo 512
  a_r7_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_TXACK && state_q == ST_TX)
    |-> cnt_q == ADDR_W'($past(cnt_q) + 1'b1));

  // R8: a missing acknowledge releases the line and ends the read
  a_r8_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TXACK && scl_fall && !ack_q && !start_det && !stop_det)
    |=> (state_q == ST_IDLE && !sda_oe));

  // R10: a STOP returns to idle
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state_q == ST_IDLE);

endmodule

bind eeprom_rd_engine eer_checker #(
  .DEV_TYPE (DEV_TYPE),
  .ADDR_W   (ADDR_W),
  .BYTE_W   (BYTE_W),
  .BIT_W    (BIT_W)
) u_eer_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_s     (scl_s),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state_q   (state_q),
  .cnt_q     (cnt_q),
  .ack_q     (ack_q),
  .bitcnt_q  (bitcnt_q),
  .shreg_q   (shreg_q)
);

// File: tb/test_eeprom_rd_engine.sv
module test_eeprom_rd_engine;

  logic clk;
  logic rst_n;
  logic scl;
  logic m_sda;
  logic sda_oe;
  logic sda_line;
  int   errors;
  int   checks;
  bit   done;

  assign sda_line = m_sda & ~sda_oe;

  eeprom_rd_engine i_eeprom_rd_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // random-read vectors: {address[8:0], expected byte}
  localparam logic [16:0] VECTORS [8] = '{
    {9'h000, 8'h2B}, {9'h001, 8'h2A}, {9'h07F, 8'h54}, {9'h080, 8'hAB},
    {9'h0FF, 8'hD4}, {9'h100, 8'hAB}, {9'h1A5, 8'h0E}, {9'h1FF, 8'h54}
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(5);
    scl = 1'b1;   wt(10);
    m_sda = 1'b0; wt(10);
    scl = 1'b0;   wt(5);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(5);
    scl = 1'b1;   wt(10);
    m_sda = 1'b1; wt(10);
  endtask

  task automatic clk_bit(input logic v, output logic s);
    m_sda = v; wt(5);
    scl = 1'b1; wt(5);
    s = sda_line; wt(5);
    scl = 1'b0; wt(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ak, output int drove);
    logic s;
    drove = 0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], s);
      if (s !== b[i]) drove++;
    end
    clk_bit(1'b1, s);
    ak = ~s;
  endtask

  task automatic read_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~m_ack, s);
  endtask

  task automatic setup_addr(input logic [8:0] a);
    logic ak;
    int   dr;
    bus_start();
    send_byte({4'hA, 2'b00, a[8], 1'b0}, ak, dr);
    check("R2 write device byte ack", 16'(ak), 16'd1);
    send_byte(a[7:0], ak, dr);
    check("R4 word address ack", 16'(ak), 16'd1);
  endtask

  task automatic begin_read(input logic a8);
    logic ak;
    int   dr;
    bus_start();
    send_byte({4'hA, 2'b00, a8, 1'b1}, ak, dr);
    check("R2 read device byte ack", 16'(ak), 16'd1);
  endtask

  initial begin
    logic [7:0] rb;
    logic       ak;
    logic       s;
    int         dr;
    errors = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1;
    wt(5);
    check("R1 sda released in reset", 16'(sda_oe), 16'd0);
    rst_n = 1'b1;
    wt(10);
    check("R1 sda released after reset", 16'(sda_oe), 16'd0);

    // R4/R5: random reads over the vector table
    for (int i = 0; i < 8; i++) begin
      setup_addr(VECTORS[i][16:8]);
      begin_read(VECTORS[i][16]);
      read_byte(1'b0, rb);
      check("R4 R5 random read data", 16'(rb), 16'(VECTORS[i][7:0]));
      bus_stop();
    end

    // R3: foreign device type
    bus_start();
    send_byte(8'hB1, ak, dr);
    check("R3 foreign type not acked", 16'(ak), 16'd0);
    check("R3 foreign type never driven", 16'(dr), 16'd0);
    send_byte(8'hA1, ak, dr);
    check("R3 no drive until next START", 16'(ak), 16'd0);
    bus_stop();

    // R6/R7: sequential read across the top of the space
    setup_addr(9'h1FE);
    begin_read(1'b1);
    read_byte(1'b1, rb); check("R6 seq byte 0x1FE", 16'(rb), 16'h55);
    read_byte(1'b1, rb); check("R6 seq byte 0x1FF", 16'(rb), 16'h54);
    read_byte(1'b1, rb); check("R7 rollover byte 0x000", 16'(rb), 16'h2B);
    read_byte(1'b0, rb); check("R7 after rollover 0x001", 16'(rb), 16'h2A);

    // R8: after NACK the line stays released
    dr = 0;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      if (s !== 1'b1) dr++;
    end
    check("R8 released after NACK", 16'(dr), 16'd0);
    bus_stop();

    // R8/R9: current-address reads continue from the retained counter
    begin_read(1'b0);
    read_byte(1'b0, rb);
    check("R8 R9 current read counter 0x002", 16'(rb), 16'h29);
    bus_stop();
    begin_read(1'b1);
    read_byte(1'b0, rb);
    check("R9 current read page bit 0x103", 16'(rb), 16'hA8);
    bus_stop();

    // R10: STOP returns to idle
    bus_start();
    send_byte(8'hA0, ak, dr);
    check("R10 device byte acked before stop", 16'(ak), 16'd1);
    bus_stop();
    wt(5);
    scl = 1'b0;
    wt(5);
    send_byte(8'hA1, ak, dr);
    check("R10 byte after STOP ignored", 16'(ak), 16'd0);
    check("R10 line undriven after STOP", 16'(dr), 16'd0);
    scl = 1'b1;
    wt(10);

    // R1: reset during a read releases the line
    begin_read(1'b0);
    rst_n = 1'b0;
    wt(3);
    check("R1 reset mid read releases sda", 16'(sda_oe), 16'd0);
    rst_n = 1'b1;
    m_sda = 1'b1;
    scl = 1'b1;
    wt(10);
    check("R1 idle after second reset", 16'(sda_oe), 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule